// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between a bus requester and a memory port. Two address windows, each 32 MB, act as aliases. Every word-aligned address inside a window stands for one bit of a matching memory region. A read in a window fetches a small group of bytes from memory and returns only the addressed bit. A write in a window performs a locked read-modify-write. That write sets or clears exactly one bit and leaves the other fetched bits unchanged. Any address outside both windows goes to memory unchanged, and the memory response comes back to the requester.

The requester side accepts one request at a time through a valid/ready handshake. The request carries an address, a byte count (1, 2 or 4), a write flag and write data. One cycle later a response pulse returns read data and an error flag. The memory side uses the same request signals and returns its own response pulse. The bridge holds one request at a time, so no other access can reach memory between the read and the write-back of an alias write.

Top module: `bitband_bridge`

## Requirements
- R1: An alias read returns the selected bit in response bit 0, and all other response bits are zero.
- R2: In a window, the memory byte address is the region base OR'd with the window offset (low 25 bits) shifted right by 5, rounded down to a multiple of the access size. The bit index is (address >> 2) masked with (size*8 - 1). Byte lanes are little-endian: the fetched byte at the lowest address occupies data bits [7:0].
- R3: An alias write reads `size` bytes, replaces the selected bit with write-data bit 0, and writes the same bytes back to the same address. No other bit changes, and the response data is zero.
- R4: The window at 0x2200_0000 maps onto memory at 0x2000_0000, and the window at 0x4200_0000 maps onto memory at 0x4000_0000. Each window spans 0x0200_0000 bytes, so 0x2400_0000 is outside the first window.
- R5: A request outside both windows reaches memory with its address, size, write flag and data unchanged, and the memory's response data and error are returned as they are.
- R6: A size field other than 1, 2 or 4 receives an error response one cycle after acceptance and causes no memory request.
- R7: If the read phase of an alias access reports an error, the error is returned and no write-back is issued.
- R8: An error on the write-back of an alias write is reported in that request's response.
- R9: From acceptance until its response, the requester port holds ready low. An alias write appears at memory as a read immediately followed by a write, with nothing in between.
- R10: After reset, ready is high, and both the response pulse and the memory request are low.
- R11: Sizes of 1, 2 and 4 bytes are accepted in a window, and the size is encoded as a plain byte count in the 3-bit size field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Requester request valid |
| s_ready | output | 1 | Bridge can accept a request |
| s_addr | input | 32 | Request byte address |
| s_size | input | 3 | Access size in bytes (1, 2, 4) |
| s_we | input | 1 | Write request |
| s_wdata | input | 32 | Write data |
| s_rsp_valid | output | 1 | Response pulse to requester |
| s_rsp_rdata | output | 32 | Response read data |
| s_rsp_err | output | 1 | Response error |
| m_valid | output | 1 | Memory request valid |
| m_ready | input | 1 | Memory accepts request |
| m_addr | output | 32 | Memory byte address |
| m_size | output | 3 | Memory access size in bytes |
| m_we | output | 1 | Memory write |
| m_wdata | output | 32 | Memory write data, little-endian lanes |
| m_rsp_valid | input | 1 | Memory response pulse |
| m_rsp_rdata | input | 32 | Memory read data, little-endian lanes |
| m_rsp_err | input | 1 | Memory response error |

## Verification
The bench builds the bridge with its default parameters: a 32-bit bus, a 25-bit window offset, and the two regions at their standard bases. These values bring both regions within reach, along with the window edge just above the first alias range and word rounding at all three access sizes. The memory model indexes each region by its low eight address bits, so bit indices above 31 land on later bytes. This lets bits written through the alias be read back as whole bytes through pass-through. Errors can be injected separately on read and write phases, and the model's operation count and order show any write-back that is suppressed or reordered.

// File: rtl/bb_pkg.sv
package bb_pkg;
    localparam int BB_ADDR_W   = 32;
    localparam int BB_DATA_W   = 32;
    localparam int BB_SIZE_W   = 3;
    // alias words are 4 bytes apart and a byte holds 8 bits: 2 + 3
    localparam int BB_BYTE_SHIFT = 5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_WR_WAIT, ST_PT_REQ, ST_PT_WAIT
    } bb_state_t;

    typedef struct packed {
        logic                 we;
        logic [BB_ADDR_W-1:0] addr;
        logic [BB_SIZE_W-1:0] size;
        logic [BB_DATA_W-1:0] wdata;
    } bb_req_t;

    function automatic logic size_ok(input logic [BB_SIZE_W-1:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction
endpackage

// File: rtl/bb_region_decode.sv
module bb_region_decode
    import bb_pkg::*;
#(
    parameter int ADDR_W      = BB_ADDR_W,
    parameter int WIN_BITS    = 25,
    parameter int NUM_REGIONS = 2,
    parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] ALIAS_BASE = '{32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] MEM_BASE   = '{32'h4000_0000, 32'h2000_0000}
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] tgt
);
    logic [NUM_REGIONS-1:0]             hit_vec;
    logic [NUM_REGIONS-1:0][ADDR_W-1:0] tgt_vec;

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
        assign hit_vec[i] = (addr[ADDR_W-1:WIN_BITS] == ALIAS_BASE[i][ADDR_W-1:WIN_BITS]);
        assign tgt_vec[i] = MEM_BASE[i] | (ADDR_W'(addr[WIN_BITS-1:0]) >> BB_BYTE_SHIFT);
    end

    always_comb begin
        tgt = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hit_vec[i]) tgt = tgt | tgt_vec[i];
        end
    end
    assign hit = |hit_vec;
endmodule

// File: rtl/bb_bit_lane.sv
module bb_bit_lane
    import bb_pkg::*;
#(
    parameter int ADDR_W = BB_ADDR_W,
    parameter int DATA_W = BB_DATA_W,
    localparam int IDX_W  = $clog2(DATA_W),
    localparam int NBYTES = DATA_W / 8
) (
    input  logic [ADDR_W-1:0]    tgt_addr,
    input  logic [IDX_W-1:0]     word_sel,
    input  logic [BB_SIZE_W-1:0] size,
    input  logic [DATA_W-1:0]    fetched,
    input  logic                 set_val,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 bit_out,
    output logic [DATA_W-1:0]    merged
);
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] keep;

    always_comb begin
        mem_addr = tgt_addr & ~(ADDR_W'(size) - ADDR_W'(1));
        idx      = word_sel & IDX_W'((32'(size) << 3) - 1);
        bit_out  = fetched[idx];
        for (int b = 0; b < NBYTES; b++) begin
            keep[b*8 +: 8] = (b < int'(size)) ? 8'hFF : 8'h00;
        end
        merged      = fetched & keep;
        merged[idx] = set_val;
    end
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
    import bb_pkg::*;
#(
    parameter int WIN_BITS    = 25,
    parameter int NUM_REGIONS = 2,
    parameter logic [NUM_REGIONS-1:0][BB_ADDR_W-1:0] ALIAS_BASE = '{32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_REGIONS-1:0][BB_ADDR_W-1:0] MEM_BASE   = '{32'h4000_0000, 32'h2000_0000}
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 s_valid,
    output logic                 s_ready,
    input  logic [BB_ADDR_W-1:0] s_addr,
    input  logic [BB_SIZE_W-1:0] s_size,
    input  logic                 s_we,
    input  logic [BB_DATA_W-1:0] s_wdata,
    output logic                 s_rsp_valid,
    output logic [BB_DATA_W-1:0] s_rsp_rdata,
    output logic                 s_rsp_err,
    output logic                 m_valid,
    input  logic                 m_ready,
    output logic [BB_ADDR_W-1:0] m_addr,
    output logic [BB_SIZE_W-1:0] m_size,
    output logic                 m_we,
    output logic [BB_DATA_W-1:0] m_wdata,
    input  logic                 m_rsp_valid,
    input  logic [BB_DATA_W-1:0] m_rsp_rdata,
    input  logic                 m_rsp_err
);
    localparam int IDX_W = $clog2(BB_DATA_W);

    bb_state_t            state;
    bb_req_t              req_q;
    logic [BB_ADDR_W-1:0] tgt_q, dec_tgt, lane_addr;
    logic [BB_DATA_W-1:0] wb_q, lane_merged;
    logic                 dec_hit, lane_bit;

    bb_region_decode #(
        .ADDR_W(BB_ADDR_W), .WIN_BITS(WIN_BITS), .NUM_REGIONS(NUM_REGIONS),
        .ALIAS_BASE(ALIAS_BASE), .MEM_BASE(MEM_BASE)
    ) u_dec (
        .addr(s_addr), .hit(dec_hit), .tgt(dec_tgt)
    );

    bb_bit_lane #(.ADDR_W(BB_ADDR_W), .DATA_W(BB_DATA_W)) u_lane (
        .tgt_addr(tgt_q), .word_sel(req_q.addr[IDX_W+1:2]), .size(req_q.size),
        .fetched(m_rsp_rdata), .set_val(req_q.wdata[0]),
        .mem_addr(lane_addr), .bit_out(lane_bit), .merged(lane_merged)
    );

    assign s_ready = (state == ST_IDLE);
    assign m_valid = (state == ST_RD_REQ) || (state == ST_WR_REQ) || (state == ST_PT_REQ);
    assign m_addr  = (state == ST_PT_REQ) ? req_q.addr : lane_addr;
    assign m_size  = req_q.size;
    assign m_we    = (state == ST_WR_REQ) || ((state == ST_PT_REQ) && req_q.we);
    assign m_wdata = (state == ST_PT_REQ) ? req_q.wdata : wb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            req_q       <= '0;
            tgt_q       <= '0;
            wb_q        <= '0;
            s_rsp_valid <= 1'b0;
            s_rsp_rdata <= '0;
            s_rsp_err   <= 1'b0;
        end else begin
            s_rsp_valid <= 1'b0;
            unique case (state)
                ST_IDLE: if (s_valid) begin
                    req_q <= '{we: s_we, addr: s_addr, size: s_size, wdata: s_wdata};
                    tgt_q <= dec_tgt;
                    if (!size_ok(s_size)) begin
                        s_rsp_valid <= 1'b1;
                        s_rsp_rdata <= '0;
                        s_rsp_err   <= 1'b1;
                    end else begin
                        state <= dec_hit ? ST_RD_REQ : ST_PT_REQ;
                    end
                end
                ST_RD_REQ: if (m_ready) state <= ST_RD_WAIT;
                ST_RD_WAIT: if (m_rsp_valid) begin
                    if (m_rsp_err) begin
                        s_rsp_valid <= 1'b1;
                        s_rsp_rdata <= '0;
                        s_rsp_err   <= 1'b1;
                        state       <= ST_IDLE;
                    end else if (req_q.we) begin
                        wb_q  <= lane_merged;
                        state <= ST_WR_REQ;
                    end else begin
                        s_rsp_valid <= 1'b1;
                        s_rsp_rdata <= BB_DATA_W'(lane_bit);
                        s_rsp_err   <= 1'b0;
                        state       <= ST_IDLE;
                    end
                end
                ST_WR_REQ: if (m_ready) state <= ST_WR_WAIT;
                ST_WR_WAIT: if (m_rsp_valid) begin
                    s_rsp_valid <= 1'b1;
                    s_rsp_rdata <= '0;
                    s_rsp_err   <= m_rsp_err;
                    state       <= ST_IDLE;
                end
                ST_PT_REQ: if (m_ready) state <= ST_PT_WAIT;
                ST_PT_WAIT: if (m_rsp_valid) begin
                    s_rsp_valid <= 1'b1;
                    s_rsp_rdata <= m_rsp_rdata;
                    s_rsp_err   <= m_rsp_err;
                    state       <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (s_ready && !s_rsp_valid && !m_valid));

    // R6
    bad_size_chk: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_ready && !size_ok(s_size)) |=> (s_rsp_valid && s_rsp_err && s_ready && !m_valid));

    // R7
    rd_err_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_WAIT && m_rsp_valid && m_rsp_err) |=> (s_rsp_valid && s_rsp_err && !m_valid));

    // R1
    bit_only_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_WAIT && m_rsp_valid && !m_rsp_err && !req_q.we)
        |=> (s_rsp_valid && s_rsp_rdata[BB_DATA_W-1:1] == '0));

    // R9
    lock_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_WAIT && m_rsp_valid && !m_rsp_err && req_q.we)
        |=> (m_valid && m_we && !s_ready && m_addr == $past(m_addr)));
endmodule

// File: tb/sim_bitband_bridge.sv
`timescale 1ns/1ps
module sim_bitband_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_valid = 1'b0, s_we = 1'b0;
    logic [31:0] s_addr = '0, s_wdata = '0;
    logic [2:0]  s_size = 3'd4;
    logic        s_ready, s_rsp_valid, s_rsp_err;
    logic [31:0] s_rsp_rdata;
    logic        m_valid, m_we;
    logic        m_ready = 1'b1;
    logic [31:0] m_addr, m_wdata;
    logic [2:0]  m_size;
    logic        m_rsp_valid = 1'b0, m_rsp_err = 1'b0;
    logic [31:0] m_rsp_rdata = '0;

    int errors = 0, checks = 0, ops = 0;
    logic [1:0] hist = 2'b00;
    logic fail_rd = 1'b0, fail_wr = 1'b0, done = 1'b0;

    always #4 clk = ~clk;

    bitband_bridge u0 (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_addr(s_addr),
        .s_size(s_size), .s_we(s_we), .s_wdata(s_wdata), .s_rsp_valid(s_rsp_valid),
        .s_rsp_rdata(s_rsp_rdata), .s_rsp_err(s_rsp_err), .m_valid(m_valid),
        .m_ready(m_ready), .m_addr(m_addr), .m_size(m_size), .m_we(m_we),
        .m_wdata(m_wdata), .m_rsp_valid(m_rsp_valid), .m_rsp_rdata(m_rsp_rdata),
        .m_rsp_err(m_rsp_err)
    );

    // memory model: region by address bit 30, byte by low 8 bits, little-endian lanes
    logic [7:0]  mem [2][256];
    logic        pend = 1'b0, perr = 1'b0;
    logic [31:0] pdata = '0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[0][i] = 8'h00;
            mem[1][i] = 8'hFF;
        end
    end

    always @(negedge clk) begin
        if (pend) begin
            m_rsp_valid = 1'b1; m_rsp_rdata = pdata; m_rsp_err = perr; pend = 1'b0;
        end else begin
            m_rsp_valid = 1'b0; m_rsp_rdata = '0; m_rsp_err = 1'b0;
        end
        if (m_valid) begin
            ops++;
            hist  = {hist[0], m_we};
            pdata = '0;
            perr  = m_we ? fail_wr : fail_rd;
            for (int b = 0; b < int'(m_size); b++) begin
                if (m_we) begin
                    if (!fail_wr) mem[m_addr[30]][m_addr[7:0] + 8'(b)] = m_wdata[b*8 +: 8];
                end else if (!fail_rd) begin
                    pdata[b*8 +: 8] = mem[m_addr[30]][m_addr[7:0] + 8'(b)];
                end
            end
            pend = 1'b1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic we, input logic [31:0] a, input logic [2:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output logic er, output int busy);
        logic got = 1'b0;
        @(negedge clk);
        while (!s_ready) @(negedge clk);
        s_valid = 1'b1; s_we = we; s_addr = a; s_size = sz; s_wdata = wd;
        @(negedge clk);
        s_valid = 1'b0;
        busy = 0; rd = '0; er = 1'b0;
        for (int t = 0; t < 50; t++) begin
            if (s_rsp_valid) begin
                rd = s_rsp_rdata; er = s_rsp_err; got = 1'b1;
                break;
            end
            if (!s_ready) busy++;
            @(negedge clk);
        end
        if (!got) check("R9 response timeout", 32'h0, 32'h1);
    endtask

    typedef struct packed {
        logic [15:0] tag;
        logic        we;
        logic [31:0] addr;
        logic [2:0]  size;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic        err;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{"R1", 1'b0, 32'h2200_0000, 3'd4, 32'h0,         32'h0,         1'b0},
        '{"R3", 1'b1, 32'h2200_0014, 3'd4, 32'h1,         32'h0,         1'b0},
        '{"R5", 1'b0, 32'h2000_0000, 3'd1, 32'h0,         32'h20,        1'b0},
        '{"R1", 1'b0, 32'h2200_0014, 3'd1, 32'h0,         32'h1,         1'b0},
        '{"R4", 1'b1, 32'h4200_0034, 3'd2, 32'hFFFF_FFFE, 32'h0,         1'b0},
        '{"R3", 1'b0, 32'h4000_0000, 3'd4, 32'h0,         32'hFFFF_DFFF, 1'b0},
        '{"R2", 1'b0, 32'h4200_0034, 3'd4, 32'h0,         32'h0,         1'b0},
        '{"R2", 1'b0, 32'h4200_0030, 3'd1, 32'h0,         32'h1,         1'b0},
        '{"R5", 1'b1, 32'h2000_0010, 3'd4, 32'h8000_0001, 32'h0,         1'b0},
        '{"R2", 1'b0, 32'h2200_027C, 3'd4, 32'h0,         32'h1,         1'b0},
        '{"R11",1'b0, 32'h2200_027C, 3'd1, 32'h0,         32'h1,         1'b0},
        '{"R11",1'b0, 32'h2200_0204, 3'd2, 32'h0,         32'h0,         1'b0},
        '{"R3", 1'b1, 32'h2200_0204, 3'd1, 32'h3,         32'h0,         1'b0},
        '{"R3", 1'b0, 32'h2000_0010, 3'd1, 32'h0,         32'h3,         1'b0},
        '{"R4", 1'b0, 32'h2400_0000, 3'd1, 32'h0,         32'h20,        1'b0},
        '{"R6", 1'b0, 32'h2200_0000, 3'd3, 32'h0,         32'h0,         1'b1}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic        er;
        int          busy, ops0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        check("R10 ready", 32'(s_ready), 32'h1);
        check("R10 rsp_valid", 32'(s_rsp_valid), 32'h0);
        check("R10 m_valid", 32'(m_valid), 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            do_req(VEC[i].we, VEC[i].addr, VEC[i].size, VEC[i].wdata, rd, er, busy);
            check($sformatf("%s vec%0d data", VEC[i].tag, i), rd, VEC[i].exp);
            check($sformatf("%s vec%0d err", VEC[i].tag, i), 32'(er), 32'(VEC[i].err));
        end

        // R6: bad sizes produce no memory traffic
        ops0 = ops;
        do_req(1'b1, 32'h2200_0000, 3'd0, 32'h1, rd, er, busy);
        check("R6 size0 err", 32'(er), 32'h1);
        do_req(1'b0, 32'h2000_0000, 3'd5, 32'h0, rd, er, busy);
        check("R6 size5 err", 32'(er), 32'h1);
        repeat (3) @(negedge clk);
        check("R6 no traffic", 32'(ops - ops0), 32'h0);

        // R7: read-phase error, no write-back
        fail_rd = 1'b1; ops0 = ops;
        do_req(1'b1, 32'h2200_0000, 3'd1, 32'h1, rd, er, busy);
        check("R7 err", 32'(er), 32'h1);
        repeat (3) @(negedge clk);
        check("R7 single op", 32'(ops - ops0), 32'h1);
        fail_rd = 1'b0;
        do_req(1'b0, 32'h2000_0000, 3'd1, 32'h0, rd, er, busy);
        check("R7 memory unchanged", rd, 32'h20);

        // R8: write-back error
        fail_wr = 1'b1; ops0 = ops;
        do_req(1'b1, 32'h2200_0004, 3'd1, 32'h1, rd, er, busy);
        check("R8 err", 32'(er), 32'h1);
        check("R8 two ops", 32'(ops - ops0), 32'h2);
        fail_wr = 1'b0;

        // R9: locked read then write, ready held low throughout
        ops0 = ops;
        do_req(1'b1, 32'h4200_0000, 3'd4, 32'h0, rd, er, busy);
        check("R9 busy cycles", 32'(busy), 32'h4);
        check("R9 op count", 32'(ops - ops0), 32'h2);
        check("R9 read then write", 32'(hist), 32'h1);
        do_req(1'b0, 32'h4000_0000, 3'd4, 32'h0, rd, er, busy);
        check("R3 cleared bit0 only", rd, 32'hFFFF_DFFE);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule